// File: doc/BRIEF.md
# Switch-Operand Adder with Two-Digit Scanned Hex Display

This block adds two small unsigned operands, both read from one bank of slide switches, together with a carry-in bit. It shows the result as hexadecimal digits on seven-segment displays. The adder is a ripple chain of single-bit full adders, each written as sum-of-products logic. The result is one bit wider than an operand. It is padded to whole nibbles, and each nibble drives its own hex glyph decoder.

The displays share one set of segment lines. A free-running refresh counter scans them in turn: its top bits pick which digit's anode is enabled, and the matching glyph is put on the segment lines. With the default 4-bit operands the sum covers 0x00 to 0x1F, so the upper digit only ever shows 0 or 1. Anode and segment outputs are registered, so the pins never glitch while the adder settles.

Top module: `adder_hex_display`

## Requirements
- R1: Operand A is sw[3:0] and operand B is sw[7:4], both unsigned.
- R2: The 5-bit result is A + B + cin. The lower display digit, digit 0, shows bits [3:0] of that result.
- R3: The upper display digit, digit 1, shows bit 4 of the result zero-extended to a nibble, so its glyph is always that of 0 or 1.
- R4: seg_n[0] drives segment a, seg_n[1] drives b, and so on up to seg_n[6] for g. A segment is lit when its bit is 0. The lit pattern, written active-high as {g..a} in hex, is: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71.
- R5: Anodes are active low. an_n[0] enables digit 0 and an_n[1] enables digit 1. In every cycle exactly one bit of an_n is 0.
- R6: The refresh counter is REFRESH_W bits wide and adds one on every clock. Its most significant bit selects the digit: 0 selects digit 0 and 1 selects digit 1. Each digit therefore stays enabled for 2^(REFRESH_W-1) consecutive cycles.
- R7: A synchronous active-high reset clears the counter. The clock edge that samples reset sets an_n to enable digit 0 and sets seg_n to all ones (blank). After reset is released, the first digit scanned is digit 0.
- R8: Outputs are registered. A change on sw or cin while digit 0 stays enabled appears on seg_n after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Board clock; drives the refresh counter and the output registers |
| rst | input | 1 | Synchronous active-high reset |
| sw | input | 8 | Slide switches: operand B in the high nibble, operand A in the low nibble |
| cin | input | 1 | Carry-in; adds one to the result |
| an_n | output | 2 | Active-low digit anode enables |
| seg_n | output | 7 | Active-low segment lines a..g, shared by both digits |

## Verification
A fault in the carry chain or in a decoder shows up as a wrong glyph at the next edge on which the affected digit is enabled. That is at most one full refresh period after the inputs settle. A stuck or skipping refresh counter shows up at the anode pins as a dwell time other than the nominal half period, or as a digit that is never enabled. A broken anode register shows in the same cycle as zero or two enabled anodes. The bench uses a 3-bit refresh counter so that it can step through every operand and carry combination and still see both digits for each one.

// File: rtl/adder_disp_pkg.sv
package adder_disp_pkg;

   typedef logic [6:0] seg_t;

   // all segments off, expressed in lit-high form
   localparam seg_t SEG_NONE_LIT = 7'h00;

   // number of hex digits needed for an (opw+1)-bit result
   function automatic int digit_count(input int opw);
      return (opw + 4) / 4;
   endfunction

   // true when v is a power of two (v >= 1)
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/adder_full_bit.sv
module adder_full_bit (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);

   // sum: odd number of ones among the three inputs, as a sum of products
   assign s = (~a & ~b &  ci) |
              (~a &  b & ~ci) |
              ( a & ~b & ~ci) |
              ( a &  b &  ci);

   // carry: at least two ones (majority), minimised sum of products
   assign co = (a & b) | (a & ci) | (b & ci);

endmodule

// File: rtl/adder_ripple.sv
module adder_ripple #(
   parameter int OPW = 4
) (
   input  logic [OPW-1:0] a,
   input  logic [OPW-1:0] b,
   input  logic           ci,
   output logic [OPW-1:0] s,
   output logic           co
);

   if (OPW < 1) begin : g_bad_width
      $error("adder_ripple: OPW must be at least 1");
   end

   logic [OPW:0] chain;
   assign chain[0] = ci;

   for (genvar i = 0; i < OPW; i++) begin : g_bit
      adder_full_bit u_fa (
         .a  (a[i]),
         .b  (b[i]),
         .ci (chain[i]),
         .s  (s[i]),
         .co (chain[i+1])
      );
   end

   assign co = chain[OPW];

endmodule

// File: rtl/adder_hex_glyph.sv
module adder_hex_glyph
   import adder_disp_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic [3:0] nib,
   output seg_t       seg
);

   seg_t lit;   // bit set = segment lit, {g,f,e,d,c,b,a}

   always_comb begin
      case (nib)
         4'h0:    lit = 7'h3F;
         4'h1:    lit = 7'h06;
         4'h2:    lit = 7'h5B;
         4'h3:    lit = 7'h4F;
         4'h4:    lit = 7'h66;
         4'h5:    lit = 7'h6D;
         4'h6:    lit = 7'h7D;
         4'h7:    lit = 7'h07;
         4'h8:    lit = 7'h7F;
         4'h9:    lit = 7'h6F;
         4'hA:    lit = 7'h77;
         4'hB:    lit = 7'h7C;
         4'hC:    lit = 7'h39;
         4'hD:    lit = 7'h5E;
         4'hE:    lit = 7'h79;
         default: lit = 7'h71;
      endcase
   end

   if (ACTIVE_LOW) begin : g_low
      assign seg = ~lit;
   end else begin : g_high
      assign seg = lit;
   end

endmodule

// File: rtl/adder_scan.sv
module adder_scan
   import adder_disp_pkg::*;
#(
   parameter int NUM_DIG        = 2,
   parameter int CNT_W          = 18,
   parameter bit SEG_ACTIVE_LOW = 1'b1,
   parameter bit AN_ACTIVE_LOW  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_DIG*4-1:0] digits,
   output logic [NUM_DIG-1:0]   an,
   output seg_t                 seg,
   output logic [CNT_W-1:0]     cnt
);

   localparam int   SELW      = $clog2(NUM_DIG);
   localparam seg_t SEG_BLANK = SEG_ACTIVE_LOW ? ~SEG_NONE_LIT : SEG_NONE_LIT;

   if (NUM_DIG < 2 || !is_pow2(NUM_DIG)) begin : g_bad_dig
      $error("adder_scan: NUM_DIG must be a power of two, at least 2");
   end
   if (CNT_W <= SELW) begin : g_bad_cnt
      $error("adder_scan: CNT_W must exceed the digit select width");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [SELW-1:0]  sel;
   seg_t             glyph [NUM_DIG];
   logic [NUM_DIG-1:0] on_hot;
   logic [NUM_DIG-1:0] an_next;
   logic [NUM_DIG-1:0] an_rst;

   assign sel = cnt_q[CNT_W-1 -: SELW];

   for (genvar g = 0; g < NUM_DIG; g++) begin : g_dec
      adder_hex_glyph #(
         .ACTIVE_LOW (SEG_ACTIVE_LOW)
      ) u_dec (
         .nib (digits[4*g +: 4]),
         .seg (glyph[g])
      );
   end

   assign on_hot = NUM_DIG'(1) << sel;

   if (AN_ACTIVE_LOW) begin : g_an_low
      assign an_next = ~on_hot;
      assign an_rst  = ~NUM_DIG'(1);
   end else begin : g_an_high
      assign an_next = on_hot;
      assign an_rst  = NUM_DIG'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         an    <= an_rst;
         seg   <= SEG_BLANK;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
         an    <= an_next;
         seg   <= glyph[sel];
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/adder_hex_display.sv
module adder_hex_display
   import adder_disp_pkg::*;
#(
   parameter int OPW            = 4,
   parameter int REFRESH_W      = 18,
   parameter bit SEG_ACTIVE_LOW = 1'b1,
   parameter bit AN_ACTIVE_LOW  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [2*OPW-1:0]              sw,
   input  logic                          cin,
   output logic [digit_count(OPW)-1:0]   an_n,
   output logic [6:0]                    seg_n
);

   localparam int NUM_DIG = digit_count(OPW);
   localparam int PADW    = NUM_DIG * 4;

   if (OPW < 4) begin : g_bad_opw
      $error("adder_hex_display: OPW must be at least 4");
   end

   logic [OPW-1:0]   op_a;
   logic [OPW-1:0]   op_b;
   logic [OPW-1:0]   sum_lo;
   logic             carry_out;
   logic [OPW:0]     sum_w;
   logic [PADW-1:0]  digits;
   logic [REFRESH_W-1:0] scan_cnt;

   assign op_a = sw[OPW-1:0];
   assign op_b = sw[2*OPW-1:OPW];

   adder_ripple #(
      .OPW (OPW)
   ) u_add (
      .a  (op_a),
      .b  (op_b),
      .ci (cin),
      .s  (sum_lo),
      .co (carry_out)
   );

   assign sum_w  = {carry_out, sum_lo};
   assign digits = PADW'(sum_w);

   adder_scan #(
      .NUM_DIG        (NUM_DIG),
      .CNT_W          (REFRESH_W),
      .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW),
      .AN_ACTIVE_LOW  (AN_ACTIVE_LOW)
   ) u_scan (
      .clk    (clk),
      .rst    (rst),
      .digits (digits),
      .an     (an_n),
      .seg    (seg_n),
      .cnt    (scan_cnt)
   );

endmodule

// File: rtl/adder_hex_display_chk.sv
module adder_hex_display_chk #(
   parameter int OPW            = 4,
   parameter int NUM_DIG        = 2,
   parameter int CNT_W          = 18,
   parameter bit SEG_ACTIVE_LOW = 1'b1,
   parameter bit AN_ACTIVE_LOW  = 1'b1
) (
   input logic                clk,
   input logic                rst,
   input logic [2*OPW-1:0]    sw,
   input logic                cin,
   input logic [NUM_DIG-1:0]  an_n,
   input logic [6:0]          seg_n,
   input logic [OPW:0]        sum_w,
   input logic [CNT_W-1:0]    cnt
);

   logic [NUM_DIG-1:0] an_on;
   logic [6:0]         seg_lit;

   assign an_on   = AN_ACTIVE_LOW  ? ~an_n  : an_n;
   assign seg_lit = SEG_ACTIVE_LOW ? ~seg_n : seg_n;

   // R2: adder result equals the arithmetic sum of the switch operands
   p_sum_r2: assert property (@(posedge clk) disable iff (rst)
      sum_w == (OPW+1)'(sw[OPW-1:0]) + (OPW+1)'(sw[2*OPW-1:OPW]) + (OPW+1)'(cin));

   // R5: exactly one anode enabled
   p_one_anode_r5: assert property (@(posedge clk) disable iff (rst)
      $countones(an_on) == 1);

   // R6: refresh counter steps by one each cycle
   p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> cnt == $past(cnt) + CNT_W'(1));

   // R7: reset enables digit 0 with blank segments
   p_reset_state_r7: assert property (@(posedge clk)
      rst |=> (an_on == NUM_DIG'(1)) && (seg_lit == 7'h00));

   // R3: upper digit only ever shows 0 or 1
   p_upper_glyph_r3: assert property (@(posedge clk) disable iff (rst)
      an_on[1] |-> (seg_lit == 7'h3F || seg_lit == 7'h06));

endmodule

bind adder_hex_display adder_hex_display_chk #(
   .OPW            (OPW),
   .NUM_DIG        (NUM_DIG),
   .CNT_W          (REFRESH_W),
   .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW),
   .AN_ACTIVE_LOW  (AN_ACTIVE_LOW)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .sw    (sw),
   .cin   (cin),
   .an_n  (an_n),
   .seg_n (seg_n),
   .sum_w (sum_w),
   .cnt   (scan_cnt)
);

// File: tb/adder_hex_display_bench.sv
module adder_hex_display_bench;

   localparam int RW = 3;   // small refresh counter: 4-cycle dwell per digit

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] sw  = 8'h00;
   logic       cin = 1'b0;
   logic [1:0] an_n;
   logic [6:0] seg_n;

   int checks = 0;
   int bad    = 0;
   int cycles = 0;

   always #4 clk = ~clk;   // 125 MHz

   adder_hex_display #(
      .OPW       (4),
      .REFRESH_W (RW)
   ) u_adder_hex_display (
      .clk   (clk),
      .rst   (rst),
      .sw    (sw),
      .cin   (cin),
      .an_n  (an_n),
      .seg_n (seg_n)
   );

   // expected active-low glyph, from the table in R4
   function automatic logic [6:0] exp_seg(input int v);
      logic [6:0] lit;
      case (v)
         0: lit = 7'h3F;  1: lit = 7'h06;  2: lit = 7'h5B;  3: lit = 7'h4F;
         4: lit = 7'h66;  5: lit = 7'h6D;  6: lit = 7'h7D;  7: lit = 7'h07;
         8: lit = 7'h7F;  9: lit = 7'h6F;  10: lit = 7'h77; 11: lit = 7'h7C;
         12: lit = 7'h39; 13: lit = 7'h5E; 14: lit = 7'h79; default: lit = 7'h71;
      endcase
      return ~lit;
   endfunction

   task automatic check(input string req, input logic ok, input int act, input int expv);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
         finish_run();
      end
   end

   initial begin
      logic [1:0] an_seq [8];
      logic [6:0] lo_seg, hi_seg;
      bit         seen_lo, seen_hi, one_ok;
      int         sum;

      // R7: state while reset is sampled
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R7 reset anode", an_n == 2'b10, an_n, 2'b10);
      check("R7 reset blank", seg_n == 7'h7F, seg_n, 7'h7F);
      rst = 1'b0;

      // R6/R7: digit 0 first, 4-cycle dwell each
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         an_seq[k] = an_n;
      end
      for (int k = 0; k < 8; k++) begin
         check("R6 R7 scan order", an_seq[k] == ((k < 4) ? 2'b10 : 2'b01),
               an_seq[k], (k < 4) ? 2'b10 : 2'b01);
      end

      // R1 R2 R3 R4 R5: every operand and carry combination
      for (int c = 0; c < 2; c++) begin
         for (int b = 0; b < 16; b++) begin
            for (int a = 0; a < 16; a++) begin
               sw  = 8'((b << 4) | a);
               cin = 1'(c);
               sum = a + b + c;
               repeat (2) @(negedge clk);
               seen_lo = 0; seen_hi = 0; one_ok = 1;
               lo_seg = '0; hi_seg = '0;
               for (int k = 0; k < 8; k++) begin
                  @(negedge clk);
                  if (an_n == 2'b10) begin seen_lo = 1; lo_seg = seg_n; end
                  else if (an_n == 2'b01) begin seen_hi = 1; hi_seg = seg_n; end
                  else one_ok = 0;
               end
               check("R5 one anode per cycle", one_ok && seen_lo && seen_hi,
                     {seen_lo, seen_hi, one_ok}, 3'b111);
               check("R1 R2 R4 lower digit", lo_seg == exp_seg(sum % 16),
                     lo_seg, exp_seg(sum % 16));
               check("R3 upper digit", hi_seg == exp_seg(sum / 16),
                     hi_seg, exp_seg(sum / 16));
            end
         end
      end

      // R8: one-edge latency while digit 0 remains enabled
      sw = 8'h00; cin = 1'b0;
      do @(negedge clk); while (an_n != 2'b01);
      do @(negedge clk); while (an_n != 2'b10);
      sw = 8'h73; cin = 1'b1;   // 3 + 7 + 1 = 0x0B
      @(negedge clk);
      check("R8 latency anode", an_n == 2'b10, an_n, 2'b10);
      check("R8 latency glyph", seg_n == exp_seg(11), seg_n, exp_seg(11));

      finish_run();
   end

endmodule